// File: doc/BRIEF.md
# Dual-Width Microprocessor Bus Bridge

This block sits between a slow, asynchronous microprocessor bus and a synchronous display-controller core. The bus has a register-select line, a read/write line, an enable strobe and eight data lines. The block samples all of these lines with the system clock and finds the edges of the enable strobe. On a write it captures the byte. On a read it drives a byte from the core onto the data lines, and it raises an output-enable that a pad ring uses to control the tri-state buffers.

The bus moves bytes either in one transfer over all eight lines or in two transfers over the upper four lines only. The block finds the width on its own. It watches the instructions written to it, and any instruction with bits 7:5 equal to 001 sets the width from its bit 4. A single phase tracker counts the two halves of a byte. Reads and writes share this tracker, so the two halves stay paired when reads and writes are mixed.

Complete bytes reach the core as one-cycle strobes of four kinds: instruction write, data write, status read and data read. For the two write kinds the assembled byte comes with the strobe.

Top module: `mpu_bus_bridge`

## Requirements
- R1: While reset is asserted, and after it is released, the block is in 8-bit mode with the nibble phase cleared, the output-enable low and no strobe active.
- R2: In 8-bit mode, a write with select=0 gives one instruction strobe and a write with select=1 gives one data-write strobe. Each strobe carries the full byte from lines 7:0 as they stood while enable was high.
- R3: In 8-bit mode, a read with select=0 drives `status_i` onto the lines (bit 7 is the busy flag) and a read with select=1 drives `rdata_i`. Each gives one strobe of the matching kind after enable falls.
- R4: The output-enable rises only after a rising edge of enable while read/write=1. It falls once enable is seen low, and it is never raised during a write.
- R5: An instruction byte whose bits 7:5 are 001 sets the width from bit 4 (1 = eight lines, 0 = four lines). `wide_o` shows the new width, and the new width applies from the next transfer on.
- R6: In 4-bit mode a write byte is built from two transfers on lines 7:4, high nibble first. Lines 3:0 are ignored.
- R7: In 4-bit mode a read presents the high nibble and then the low nibble on lines 7:4, with lines 3:0 driven to 0. The whole byte is latched at the first rising edge of enable, so a change in the core value between the two halves does not reach the bus.
- R8: In 4-bit mode no strobe follows the first transfer of a byte. The phase is shared by reads and writes, and the strobe kind follows the second transfer.
- R9: Each strobe lasts exactly one clock cycle, and at most one strobe is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel_i | input | 1 | Register select: 0 instruction/status, 1 data |
| bus_rd_i | input | 1 | 1 read, 0 write |
| bus_en_i | input | 1 | Asynchronous transfer enable strobe |
| bus_d_i | input | 8 | Data lines as seen by the block |
| bus_d_o | output | 8 | Data driven during reads |
| bus_d_oe_o | output | 1 | Output-enable for the data-line buffers |
| status_i | input | 8 | Busy flag (bit 7) and address counter from the core |
| rdata_i | input | 8 | Read data byte from the core |
| cmd_stb_o | output | 1 | Instruction byte complete |
| wdat_stb_o | output | 1 | Data write byte complete |
| stat_stb_o | output | 1 | Status read complete |
| rdat_stb_o | output | 1 | Data read complete |
| wbyte_o | output | 8 | Assembled write byte, valid with the write strobes |
| wide_o | output | 1 | 1 = 8-bit transfers, 0 = 4-bit transfers |

## Verification
A phase tracker that has drifted out of step shows on the very next byte. Either a strobe appears after a lone first nibble, or the byte comes out with its nibbles swapped, or the read lines show the wrong half during the next enable pulse. A wrong width bit shows within one transfer as a strobe count that does not match the number of enable pulses. A read latch that reloads at the wrong time shows only when the core value changes between the two halves of a read, so the bench changes the status value in that gap on purpose.

// File: rtl/mpu_bus_pkg.sv
package mpu_bus_pkg;

    localparam int BUS_W = 8;
    localparam int NIB_W = BUS_W / 2;

    typedef struct packed {
        logic             sel;
        logic             rd;
        logic [BUS_W-1:0] d;
    } bus_ctl_t;

    typedef enum logic [2:0] {
        XK_NONE,
        XK_CMD,
        XK_WDAT,
        XK_STAT,
        XK_RDAT
    } xfer_kind_t;

    function automatic xfer_kind_t kind_of(input logic sel, input logic rd);
        if (rd) return sel ? XK_RDAT : XK_STAT;
        return sel ? XK_WDAT : XK_CMD;
    endfunction

    function automatic logic is_width_cmd(input logic [BUS_W-1:0] b);
        return b[BUS_W-1 -: 3] == 3'b001;
    endfunction

endpackage

// File: rtl/mpu_bus_sync.sv
module mpu_bus_sync
    import mpu_bus_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     en_i,
    input  bus_ctl_t ctl_i,
    output logic     rise_o,
    output logic     fall_o,
    output logic     en_lvl_o,
    output bus_ctl_t ctl_rise_o,
    output bus_ctl_t ctl_fall_o
);

    localparam int LAST = SYNC_STAGES;

    logic [LAST:0] e_pipe;
    bus_ctl_t      c_pipe [0:LAST];

    always_ff @(posedge clk) begin
        if (rst) begin
            e_pipe[0] <= 1'b0;
            c_pipe[0] <= '0;
        end else begin
            e_pipe[0] <= en_i;
            c_pipe[0] <= ctl_i;
        end
    end

    for (genvar i = 1; i <= LAST; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                e_pipe[i] <= 1'b0;
                c_pipe[i] <= '0;
            end else begin
                e_pipe[i] <= e_pipe[i-1];
                c_pipe[i] <= c_pipe[i-1];
            end
        end
    end

    assign rise_o     =  e_pipe[LAST-1] & ~e_pipe[LAST];
    assign fall_o     = ~e_pipe[LAST-1] &  e_pipe[LAST];
    assign en_lvl_o   =  e_pipe[LAST-1];
    assign ctl_rise_o =  c_pipe[LAST-1];
    assign ctl_fall_o =  c_pipe[LAST];

endmodule

// File: rtl/mpu_nibble_seq.sv
module mpu_nibble_seq
    import mpu_bus_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fall_i,
    input  bus_ctl_t         ctl_i,
    output logic             wide_o,
    output logic             phase_o,
    output xfer_kind_t       kind_o,
    output logic [BUS_W-1:0] byte_o
);

    logic             wide_q;
    logic             phase_q;
    logic [NIB_W-1:0] hi_q;
    xfer_kind_t       kind_q;
    logic [BUS_W-1:0] byte_q;
    logic [BUS_W-1:0] whole;

    always_comb begin
        if (wide_q) whole = ctl_i.d;
        else        whole = {hi_q, ctl_i.d[BUS_W-1 -: NIB_W]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wide_q  <= 1'b1;
            phase_q <= 1'b0;
            hi_q    <= '0;
            kind_q  <= XK_NONE;
            byte_q  <= '0;
        end else begin
            kind_q <= XK_NONE;
            if (fall_i) begin
                if (!wide_q && !phase_q) begin
                    hi_q    <= ctl_i.d[BUS_W-1 -: NIB_W];
                    phase_q <= 1'b1;
                end else begin
                    phase_q <= 1'b0;
                    kind_q  <= kind_of(ctl_i.sel, ctl_i.rd);
                    if (!ctl_i.rd) byte_q <= whole;
                    if (!ctl_i.sel && !ctl_i.rd && is_width_cmd(whole))
                        wide_q <= whole[NIB_W];
                end
            end
        end
    end

    assign wide_o  = wide_q;
    assign phase_o = phase_q;
    assign kind_o  = kind_q;
    assign byte_o  = byte_q;

    // R1: reset state
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (wide_q && !phase_q && kind_q == XK_NONE));

    // R5: width changes only together with an instruction strobe
    assert_width_on_cmd_R5: assert property (@(posedge clk) disable iff (rst)
        (wide_q != $past(wide_q)) |-> (kind_q == XK_CMD));

    // R8: never a strobe while half a byte is pending
    assert_no_strobe_midbyte_R8: assert property (@(posedge clk) disable iff (rst)
        phase_q |-> (kind_q == XK_NONE));

    // R9: strobes last one cycle
    assert_strobe_one_cycle_R9: assert property (@(posedge clk) disable iff (rst)
        (kind_q != XK_NONE) |=> (kind_q == XK_NONE));

endmodule

// File: rtl/mpu_read_mux.sv
module mpu_read_mux
    import mpu_bus_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rise_i,
    input  logic             en_lvl_i,
    input  logic             sel_i,
    input  logic             rd_i,
    input  logic             wide_i,
    input  logic             phase_i,
    input  logic [BUS_W-1:0] status_i,
    input  logic [BUS_W-1:0] rdata_i,
    output logic [BUS_W-1:0] d_o,
    output logic             oe_o
);

    logic [BUS_W-1:0] lat_q;
    logic             oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q <= '0;
            oe_q  <= 1'b0;
        end else if (rise_i && rd_i) begin
            oe_q <= 1'b1;
            if (wide_i || !phase_i) lat_q <= sel_i ? rdata_i : status_i;
        end else if (!en_lvl_i) begin
            oe_q <= 1'b0;
        end
    end

    always_comb begin
        if (wide_i)       d_o = lat_q;
        else if (phase_i) d_o = {lat_q[NIB_W-1:0], {NIB_W{1'b0}}};
        else              d_o = {lat_q[BUS_W-1 -: NIB_W], {NIB_W{1'b0}}};
    end

    assign oe_o = oe_q;

    // R4: output-enable held only while enable is seen high
    assert_oe_while_high_R4: assert property (@(posedge clk) disable iff (rst)
        oe_q |-> $past(en_lvl_i));

    // R4: output-enable starts only from a read edge
    assert_oe_from_read_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(oe_q) |-> $past(rise_i && rd_i));

endmodule

// File: rtl/mpu_bus_bridge.sv
module mpu_bus_bridge
    import mpu_bus_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_sel_i,
    input  logic       bus_rd_i,
    input  logic       bus_en_i,
    input  logic [7:0] bus_d_i,
    output logic [7:0] bus_d_o,
    output logic       bus_d_oe_o,
    input  logic [7:0] status_i,
    input  logic [7:0] rdata_i,
    output logic       cmd_stb_o,
    output logic       wdat_stb_o,
    output logic       stat_stb_o,
    output logic       rdat_stb_o,
    output logic [7:0] wbyte_o,
    output logic       wide_o
);

    bus_ctl_t   ctl_in, ctl_rise, ctl_fall;
    logic       rise, fall, en_lvl, wide, phase;
    xfer_kind_t kind;

    assign ctl_in = '{sel: bus_sel_i, rd: bus_rd_i, d: bus_d_i};

    mpu_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk        (clk),
        .rst        (rst),
        .en_i       (bus_en_i),
        .ctl_i      (ctl_in),
        .rise_o     (rise),
        .fall_o     (fall),
        .en_lvl_o   (en_lvl),
        .ctl_rise_o (ctl_rise),
        .ctl_fall_o (ctl_fall)
    );

    mpu_nibble_seq seq_i (
        .clk     (clk),
        .rst     (rst),
        .fall_i  (fall),
        .ctl_i   (ctl_fall),
        .wide_o  (wide),
        .phase_o (phase),
        .kind_o  (kind),
        .byte_o  (wbyte_o)
    );

    mpu_read_mux rmux_i (
        .clk      (clk),
        .rst      (rst),
        .rise_i   (rise),
        .en_lvl_i (en_lvl),
        .sel_i    (ctl_rise.sel),
        .rd_i     (ctl_rise.rd),
        .wide_i   (wide),
        .phase_i  (phase),
        .status_i (status_i),
        .rdata_i  (rdata_i),
        .d_o      (bus_d_o),
        .oe_o     (bus_d_oe_o)
    );

    assign cmd_stb_o  = (kind == XK_CMD);
    assign wdat_stb_o = (kind == XK_WDAT);
    assign stat_stb_o = (kind == XK_STAT);
    assign rdat_stb_o = (kind == XK_RDAT);
    assign wide_o     = wide;

    // R9: at most one strobe at a time
    assert_single_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_stb_o, wdat_stb_o, stat_stb_o, rdat_stb_o}));

endmodule

// File: tb/mpu_bus_bridge_tb.sv
module mpu_bus_bridge_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel_i = 1'b0, bus_rd_i = 1'b0, bus_en_i = 1'b0;
    logic [7:0] bus_d_i = 8'h00, status_i = 8'h00, rdata_i = 8'h00;
    logic [7:0] bus_d_o, wbyte_o;
    logic       bus_d_oe_o, cmd_stb_o, wdat_stb_o, stat_stb_o, rdat_stb_o, wide_o;

    always #2 clk = ~clk;

    mpu_bus_bridge dut_i (
        .clk(clk), .rst(rst), .bus_sel_i(bus_sel_i), .bus_rd_i(bus_rd_i),
        .bus_en_i(bus_en_i), .bus_d_i(bus_d_i), .bus_d_o(bus_d_o),
        .bus_d_oe_o(bus_d_oe_o), .status_i(status_i), .rdata_i(rdata_i),
        .cmd_stb_o(cmd_stb_o), .wdat_stb_o(wdat_stb_o), .stat_stb_o(stat_stb_o),
        .rdat_stb_o(rdat_stb_o), .wbyte_o(wbyte_o), .wide_o(wide_o)
    );

    int checks = 0, failures = 0;
    int cnt [4];
    int n_multi = 0, n_long = 0;
    logic [7:0] last_w = 8'h00;
    logic [3:0] prev_s = 4'h0;
    logic exp_wide = 1'b1;
    bit done = 0;

    // vector: {sel, rd, byte}; for reads the byte is the core value
    localparam int NV = 13;
    localparam logic [9:0] VECS [NV] = '{
        {2'b00, 8'h38}, {2'b10, 8'h41}, {2'b01, 8'h8A}, {2'b11, 8'h5C},
        {2'b00, 8'h20}, {2'b00, 8'h28}, {2'b10, 8'hC3}, {2'b01, 8'h37},
        {2'b11, 8'hE1}, {2'b10, 8'h7E}, {2'b00, 8'h30}, {2'b10, 8'h99},
        {2'b11, 8'h66}
    };

    always @(negedge clk) begin
        logic [3:0] s;
        s = {cmd_stb_o, wdat_stb_o, stat_stb_o, rdat_stb_o};
        if (rst) begin
            prev_s = 4'h0;
        end else begin
            if ($countones(s) > 1) n_multi++;
            if ((s & prev_s) != 4'h0) n_long++;
            prev_s = s;
            if (cmd_stb_o)  begin cnt[0]++; last_w = wbyte_o; end
            if (wdat_stb_o) begin cnt[1]++; last_w = wbyte_o; end
            if (stat_stb_o) cnt[2]++;
            if (rdat_stb_o) cnt[3]++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic pulse(input logic sel, input logic rd, input logic [7:0] d,
                         output logic [7:0] seen, output logic seen_oe);
        @(negedge clk);
        bus_sel_i = sel; bus_rd_i = rd; bus_d_i = d;
        repeat (3) @(negedge clk);
        bus_en_i = 1'b1;
        repeat (7) @(negedge clk);
        seen = bus_d_o; seen_oe = bus_d_oe_o;
        repeat (3) @(negedge clk);
        bus_en_i = 1'b0;
        @(negedge clk);
        bus_d_i = 8'hFF;
        repeat (10) @(negedge clk);
    endtask

    task automatic xact(input logic sel, input logic rd, input logic [7:0] v);
        int c0 [4];
        int k;
        logic [7:0] got;
        logic goe;
        string req;
        req = rd ? (exp_wide ? "R3" : "R7") : (exp_wide ? "R2" : "R6");
        c0 = cnt;
        if (rd) begin
            if (sel) rdata_i = v; else status_i = v;
        end
        if (exp_wide) begin
            pulse(sel, rd, v, got, goe);
            if (rd) begin
                chk(goe == 1'b1, "R4", "read oe", goe, 1);
                chk(got == v, req, "read byte", got, v);
            end else begin
                chk(goe == 1'b0, "R4", "write oe", goe, 0);
            end
        end else begin
            pulse(sel, rd, {v[7:4], 4'hA}, got, goe);
            if (rd) chk(got == {v[7:4], 4'h0}, req, "high nibble", got, {v[7:4], 4'h0});
            else    chk(goe == 1'b0, "R4", "write oe", goe, 0);
            chk(cnt == c0, "R8", "strobe after first nibble", 1, 0);
            pulse(sel, rd, {v[3:0], 4'h5}, got, goe);
            if (rd) chk(got == {v[3:0], 4'h0}, req, "low nibble", got, {v[3:0], 4'h0});
        end
        k = sel ? (rd ? 3 : 1) : (rd ? 2 : 0);
        for (int j = 0; j < 4; j++)
            chk(cnt[j] - c0[j] == ((j == k) ? 1 : 0), req, "strobe count",
                cnt[j] - c0[j], (j == k) ? 1 : 0);
        if (!rd) chk(last_w == v, req, "write byte", last_w, v);
        if (!sel && !rd && v[7:5] == 3'b001) exp_wide = v[4];
        chk(wide_o == exp_wide, "R5", "width", wide_o, exp_wide);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] got;
        logic goe;
        int c0 [4];
        for (int j = 0; j < 4; j++) cnt[j] = 0;
        repeat (4) @(negedge clk);
        // R1: state during reset
        chk(wide_o == 1'b1, "R1", "wide in reset", wide_o, 1);
        chk(bus_d_oe_o == 1'b0, "R1", "oe in reset", bus_d_oe_o, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(cnt[0] + cnt[1] + cnt[2] + cnt[3] == 0, "R1", "no strobe after reset",
            cnt[0] + cnt[1] + cnt[2] + cnt[3], 0);

        for (int i = 0; i < NV; i++)
            xact(VECS[i][9], VECS[i][8], VECS[i][7:0]);

        // R8: lone half write, then a read completes the byte with read kind
        xact(1'b0, 1'b0, 8'h20);
        c0 = cnt;
        pulse(1'b1, 1'b0, 8'hB0, got, goe);
        chk(cnt == c0, "R8", "no strobe after lone half", 1, 0);
        pulse(1'b1, 1'b1, 8'h00, got, goe);
        chk(cnt[3] - c0[3] == 1, "R8", "kind follows second transfer", cnt[3] - c0[3], 1);
        chk(cnt[1] - c0[1] == 0, "R8", "no write strobe", cnt[1] - c0[1], 0);

        // R7: core value changes between halves, latched byte survives
        status_i = 8'hA5;
        pulse(1'b0, 1'b1, 8'h00, got, goe);
        chk(got == 8'hA0, "R7", "status high nibble", got, 8'hA0);
        status_i = 8'h00;
        pulse(1'b0, 1'b1, 8'h00, got, goe);
        chk(got == 8'h50, "R7", "status low nibble from latch", got, 8'h50);

        // R1: reset with half a byte pending
        pulse(1'b1, 1'b0, 8'hC0, got, goe);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(wide_o == 1'b1, "R1", "wide after reset", wide_o, 1);
        exp_wide = 1'b1;
        xact(1'b0, 1'b0, 8'h01);

        chk(n_multi == 0, "R9", "multiple strobes", n_multi, 0);
        chk(n_long == 0, "R9", "strobe longer than one cycle", n_long, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule